// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Detector

This block watches a group of general-purpose input pins and turns selected activity on them into one interrupt request. Each pin can be set to react to a level or to an edge. In edge mode a pin fires on one chosen edge, or on both edges when its both-edges bit is set. In level mode its status simply follows whether the pin is at its active level.

The pins first pass through a synchronizer. Edges are found by comparing the synchronized value with its value one clock earlier. Edge events are held in a per-pin raw status bit until software clears them. A mask register selects which raw bits reach the single interrupt output.

Software reaches every register over a simple synchronous bus. Word offsets are given relative to the port base. Read data appears one clock after the read request.

Top module: `gpio_irq_unit`

## Requirements
- R1: After synchronous reset every configuration register (sense, both-edges, event, mask) and every status bit is 0, and `irq` is low.
- R2: Only bits 7:0 of a register are implemented. Bits 31:8 always read as 0 and ignore writes. Offsets that are not mapped read as 0 and ignore writes.
- R3: The sense register is read/write at 0x404 (bit = 1 selects level mode, bit = 0 selects edge mode). The both-edges register is read/write at 0x408. The event register is read/write at 0x40C. The mask register is read/write at 0x410. A written value reads back at the same offset.
- R4: For a pin in edge mode whose both-edges bit is 1, a rising edge and a falling edge each set its raw status bit, whatever its event bit holds.
- R5: For a pin in edge mode whose both-edges bit is 0, event bit = 1 makes only rising edges set raw status, and event bit = 0 makes only falling edges set it.
- R6: For a pin in level mode, raw status follows the pin for as long as the level is held. Event bit = 1 makes high the active level and event bit = 0 makes low the active level. The both-edges bit and the clear register have no effect on such a pin.
- R7: A pin change is first seen by the status logic at the third rising clock edge after the change: two synchronizer stages, then the status register.
- R8: An edge-set raw bit stays at 1 until a 1 is written to its bit at offset 0x41C. Writing 0 leaves it unchanged. A new edge that arrives in the same cycle as a clear keeps the bit set.
- R9: The masked status at 0x418 reads as raw status AND mask. `irq` is high exactly when any masked status bit is 1.
- R10: Raw status at 0x414 and masked status at 0x418 are read-only, and writes to them are ignored. The clear register at 0x41C always reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Asynchronous pin levels |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset from the port base; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read request |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The bench builds the block with its default parameters: eight pins, a 32-bit data bus, a 12-bit offset and two synchronizer stages. At these values the upper 24 reserved bits can be checked on every register, and the exact latency of two synchronizer stages plus one status register can be measured on the interrupt line. Eight pins leave room for all four edge-mode combinations of both-edges and event bits, plus both level polarities, in one configuration. Each pin pattern therefore exercises every detection path at once.

// File: rtl/gpio_irq_pkg.sv
// Package: shared offsets and register-select type for the GPIO interrupt
// detector. Assumes word-aligned byte offsets within a 4 KiB port window.
package gpio_irq_pkg;

    localparam int OFFS_W = 12;

    localparam logic [OFFS_W-1:0] OFFS_SENSE = 12'h404;
    localparam logic [OFFS_W-1:0] OFFS_BOTH  = 12'h408;
    localparam logic [OFFS_W-1:0] OFFS_EVENT = 12'h40C;
    localparam logic [OFFS_W-1:0] OFFS_MASK  = 12'h410;
    localparam logic [OFFS_W-1:0] OFFS_RAW   = 12'h414;
    localparam logic [OFFS_W-1:0] OFFS_MSTAT = 12'h418;
    localparam logic [OFFS_W-1:0] OFFS_CLR   = 12'h41C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SENSE,
        SEL_BOTH,
        SEL_EVENT,
        SEL_MASK,
        SEL_RAW,
        SEL_MSTAT,
        SEL_CLR
    } reg_sel_e;

endpackage

// File: rtl/gpio_irq_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is an independent level; no bus coherence is implied.
module gpio_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pin vector through the flop chain, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: per-pin edge/level detection and raw status storage.
// Assumes cur_lvl is already synchronous to clk. Config inputs come from
// registers; clr_req is a one-cycle write-1-to-clear pulse.
module gpio_irq_detect #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] cur_lvl,
    input  logic [NUM_PINS-1:0] cfg_level,
    input  logic [NUM_PINS-1:0] cfg_both,
    input  logic [NUM_PINS-1:0] cfg_event,
    input  logic [NUM_PINS-1:0] clr_req,
    output logic [NUM_PINS-1:0] raw_stat
);

    logic [NUM_PINS-1:0] prev_lvl_q;
    logic [NUM_PINS-1:0] raw_q;

    // Remember the synchronized level from one clock earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl_q <= '0;
        else        prev_lvl_q <= cur_lvl;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic rise_w, fall_w, edge_hit_w, level_hit_w;

        // Classify this pin's transition and decide if it qualifies.
        always_comb begin
            rise_w      = cur_lvl[p] & ~prev_lvl_q[p];
            fall_w      = ~cur_lvl[p] & prev_lvl_q[p];
            edge_hit_w  = cfg_both[p] ? (rise_w | fall_w)
                                      : (cfg_event[p] ? rise_w : fall_w);
            level_hit_w = (cur_lvl[p] == cfg_event[p]);
        end

        // Update raw status: level mode tracks, edge mode latches until cleared.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_q[p] <= 1'b0;
            end else if (cfg_level[p]) begin
                raw_q[p] <= level_hit_w;
            end else begin
                raw_q[p] <= edge_hit_w | (raw_q[p] & ~clr_req[p]);
            end
        end

        assert_both_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_level[p] && cfg_both[p] && (cur_lvl[p] != prev_lvl_q[p])) |=> raw_q[p]);

        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_level[p] && raw_q[p] && !clr_req[p]) |=> raw_q[p]);

        assert_level_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_level[p] && (cur_lvl[p] == cfg_event[p])) |=> raw_q[p]);

        assert_level_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_level[p] && (cur_lvl[p] != cfg_event[p])) |=> !raw_q[p]);
    end

    assign raw_stat = raw_q;

endmodule

// File: rtl/gpio_irq_regs.sv
// Module: register file and bus decode for the GPIO interrupt detector.
// Assumes a single-cycle bus request; read data is registered and valid one
// clock after the request. Byte-offset bits below the word are ignored.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] raw_stat,
    output logic [NUM_PINS-1:0] cfg_level,
    output logic [NUM_PINS-1:0] cfg_both,
    output logic [NUM_PINS-1:0] cfg_event,
    output logic [NUM_PINS-1:0] cfg_mask,
    output logic [NUM_PINS-1:0] clr_req
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int RSV_W  = DATA_W - NUM_PINS;

    logic                wr_en, rd_en;
    logic [WORD_W-1:0]   word_idx;
    reg_sel_e            sel;
    logic [NUM_PINS-1:0] wr_bits;
    logic [NUM_PINS-1:0] rd_bits;
    logic [NUM_PINS-1:0] level_q, both_q, event_q, mask_q;
    logic                unused_bus_bits;

    assign unused_bus_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:NUM_PINS]};

    // Map a word index onto one of the implemented registers.
    function automatic reg_sel_e decode(input logic [WORD_W-1:0] w);
        if      (w == OFFS_SENSE[ADDR_W-1:2]) return SEL_SENSE;
        else if (w == OFFS_BOTH[ADDR_W-1:2])  return SEL_BOTH;
        else if (w == OFFS_EVENT[ADDR_W-1:2]) return SEL_EVENT;
        else if (w == OFFS_MASK[ADDR_W-1:2])  return SEL_MASK;
        else if (w == OFFS_RAW[ADDR_W-1:2])   return SEL_RAW;
        else if (w == OFFS_MSTAT[ADDR_W-1:2]) return SEL_MSTAT;
        else if (w == OFFS_CLR[ADDR_W-1:2])   return SEL_CLR;
        else                                  return SEL_NONE;
    endfunction

    // Split the bus request into read/write strobes and a register select.
    always_comb begin
        wr_en    = bus_sel & bus_wr;
        rd_en    = bus_sel & ~bus_wr;
        word_idx = bus_addr[ADDR_W-1:2];
        sel      = decode(word_idx);
        wr_bits  = bus_wdata[NUM_PINS-1:0];
    end

    // Write the configuration registers; reserved data bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            both_q  <= '0;
            event_q <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_SENSE: level_q <= wr_bits;
                SEL_BOTH:  both_q  <= wr_bits;
                SEL_EVENT: event_q <= wr_bits;
                SEL_MASK:  mask_q  <= wr_bits;
                default: ;
            endcase
        end
    end

    // Produce the one-cycle clear pulse from a write to the clear offset.
    always_comb begin
        clr_req = (wr_en && sel == SEL_CLR) ? wr_bits : '0;
    end

    // Select the implemented bits to return for a read.
    always_comb begin
        case (sel)
            SEL_SENSE: rd_bits = level_q;
            SEL_BOTH:  rd_bits = both_q;
            SEL_EVENT: rd_bits = event_q;
            SEL_MASK:  rd_bits = mask_q;
            SEL_RAW:   rd_bits = raw_stat;
            SEL_MSTAT: rd_bits = raw_stat & mask_q;
            default:   rd_bits = '0;
        endcase
    end

    // Register read data, zero-extended over the reserved bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= {{RSV_W{1'b0}}, rd_bits};
        else            bus_rdata <= '0;
    end

    assign cfg_level = level_q;
    assign cfg_both  = both_q;
    assign cfg_event = event_q;
    assign cfg_mask  = mask_q;

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_PINS] == '0);

    assert_clr_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_CLR) |=> (bus_rdata == '0));

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(level_q) && $stable(both_q) && $stable(event_q) && $stable(mask_q)));

endmodule

// File: rtl/gpio_irq_unit.sv
// Module: top of the GPIO interrupt detector. Synchronizes the pins, runs
// per-pin detection, hosts the register file and combines the masked
// status into one interrupt request. Assumes one clock domain.
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = OFFS_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq
);

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] raw_stat;
    logic [NUM_PINS-1:0] cfg_level, cfg_both, cfg_event, cfg_mask, clr_req;

    gpio_irq_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_irq_detect #(
        .NUM_PINS (NUM_PINS)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_lvl   (pin_sync),
        .cfg_level (cfg_level),
        .cfg_both  (cfg_both),
        .cfg_event (cfg_event),
        .clr_req   (clr_req),
        .raw_stat  (raw_stat)
    );

    gpio_irq_regs #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .raw_stat  (raw_stat),
        .cfg_level (cfg_level),
        .cfg_both  (cfg_both),
        .cfg_event (cfg_event),
        .cfg_mask  (cfg_mask),
        .clr_req   (clr_req)
    );

    // Combine every masked status bit into the single request line.
    always_comb begin
        irq = |(raw_stat & cfg_mask);
    end

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mask == '0) |-> !irq);

    assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_stat != '0));

endmodule

// File: tb/sim_gpio_irq_unit.sv
// Bench: scoreboard-driven check of the GPIO interrupt detector.
module sim_gpio_irq_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int DW = 32;
    localparam int AW = 12;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] exp;
        string         tag;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;
    logic          rd_pend = 1'b0;

    int checks = 0;
    int failures = 0;
    sb_item_t sb_q[$];

    gpio_irq_unit #(
        .NUM_PINS (NP),
        .DATA_W   (DW),
        .ADDR_W   (AW)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Mark the cycle after a read request as carrying read data.
    always @(posedge clk) rd_pend <= rst_n && bus_sel && !bus_wr;

    // Monitor: pop one expected item per returned read and compare.
    always @(negedge clk) begin
        if (rd_pend) begin
            sb_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                failures++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, bus_rdata, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        @(negedge clk);
        sb_q.push_back('{addr: a, exp: e, tag: tag});
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_irq(1'b0, "R1");
        bus_read(12'h404, 32'h0, "R1");
        bus_read(12'h408, 32'h0, "R1");
        bus_read(12'h40C, 32'h0, "R1");
        bus_read(12'h410, 32'h0, "R1");
        bus_read(12'h414, 32'h0, "R1");
        bus_read(12'h418, 32'h0, "R1");

        // R2/R3: configuration with reserved bits set
        bus_write(12'h40C, 32'hFFFF_FF55);
        bus_read(12'h40C, 32'h55, "R2");
        bus_write(12'h408, 32'h0000_0043);
        bus_read(12'h408, 32'h43, "R3");
        bus_write(12'h410, 32'h0000_0001);
        bus_read(12'h410, 32'h01, "R3");
        bus_write(12'h404, 32'hABCD_12F0);
        bus_read(12'h404, 32'hF0, "R3");

        // R6: level pins idle low: pins 5 and 7 are low-active
        bus_read(12'h414, 32'hA0, "R6");
        check_irq(1'b0, "R9");

        // R2: unmapped offset; R10: read-only status
        bus_write(12'h400, 32'hFFFF_FFFF);
        bus_read(12'h400, 32'h0, "R2");
        bus_write(12'h414, 32'hFF);
        bus_read(12'h414, 32'hA0, "R10");
        bus_write(12'h418, 32'hFF);
        bus_read(12'h418, 32'h00, "R10");

        // R7: latency of a rise on pin 0 to irq
        set_pins(8'h0F);
        @(negedge clk);
        @(negedge clk);
        check_irq(1'b0, "R7");
        @(negedge clk);
        check_irq(1'b1, "R7");
        settle();

        // R4/R5: rising pattern
        bus_read(12'h414, 32'hA7, "R4");
        bus_read(12'h418, 32'h01, "R9");

        // R8: sticky status and write-1-to-clear
        bus_write(12'h41C, 32'h0);
        bus_read(12'h414, 32'hA7, "R8");
        bus_write(12'h41C, 32'h01);
        bus_read(12'h414, 32'hA6, "R8");
        check_irq(1'b0, "R8");
        bus_read(12'h41C, 32'h0, "R10");
        bus_write(12'h41C, 32'hFF);
        bus_read(12'h414, 32'hA0, "R8");

        // R4/R5: falling pattern
        set_pins(8'h00);
        settle();
        bus_read(12'h414, 32'hAB, "R5");
        bus_write(12'h41C, 32'h0F);
        bus_read(12'h414, 32'hA0, "R8");

        // R6: level pins driven high
        set_pins(8'hF0);
        settle();
        bus_read(12'h414, 32'h50, "R6");
        bus_write(12'h41C, 32'hF0);
        bus_read(12'h414, 32'h50, "R6");

        // R9: mask and combined output
        bus_write(12'h410, 32'h50);
        bus_read(12'h418, 32'h50, "R9");
        check_irq(1'b1, "R9");
        bus_write(12'h410, 32'h00);
        check_irq(1'b0, "R9");

        // R6: level status follows release
        set_pins(8'h00);
        settle();
        bus_read(12'h414, 32'hA0, "R6");

        wait (sb_q.size() == 0);
        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule